// File: doc/BRIEF.md
# Bit-Parallel Implication Candidate Miner

This block mines candidate logic implications from packed simulation results. A batch carries one 32-bit word per circuit node. Bit p of a node's word is that node's value under input pattern p, so a single batch covers 32 patterns at once. For every pair of distinct nodes (i, j), the block keeps a record of which of the four value combinations (i, j) ∈ {00, 01, 10, 11} has appeared in any pattern since the last start. The block judges whether a combination is present by reducing masked words such as `a & ~b` to a single bit. It never walks the 32 patterns one at a time.

A run works as follows. A `start` pulse clears the record. The host then sends batches over a valid/ready input, and the block folds each accepted batch into its record. It visits one unordered pair per cycle and fills in both orientations of that pair at once. The batch flagged as last ends the input phase. After that batch is folded, the block scans the ordered pairs and streams the surviving candidates out one per cycle over a valid/ready output. A single-cycle `scan_done` pulse closes the stream.

Every candidate is only potential. It says that no applied pattern contradicted the relation. It does not claim the relation holds for every input.

Top module: `implication_miner`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `scan_done` are low, and they stay low until `start` is pulsed.
- R2: A cycle with `start` high clears every combination record and abandons any batch folding or candidate emission in progress. In the following cycle, `in_ready` is high and `out_valid` is low.
- R3: Node k's word occupies `in_words[32k+31:32k]`. A batch is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low during the cycles that follow, while the batch is folded (one cycle per unordered node pair).
- R4: A combination (i=u, j=v) counts as observed when some bit position of some batch accepted since the last `start` has node i equal to u and node j equal to v.
- R5: The block emits the candidate "i=x implies j=y" exactly when (i=x, j=y) is observed, (i=x, j=not y) is never observed, and at least two of the four combinations for (i, j) are observed.
- R6: No candidate has i equal to j. A pair in which both nodes held a single constant value over all patterns emits no candidate.
- R7: Candidates leave in ascending i, then ascending j, then ascending x.
- R8: `out_cand` is packed as {i, j, x, y}. i fills the top IDXW bits, j the next IDXW bits, x is bit 1 and y is bit 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_cand` keep their values into the next cycle.
- R10: Once the scan ends, `scan_done` is high for exactly one cycle with `out_valid` low. The block then holds `in_ready` low until the next `start`.
- R11: After a batch accepted with `in_last` low has been folded, `in_ready` returns high and no candidate is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clear records and begin a new run |
| in_valid | input | 1 | Batch present on `in_words` |
| in_ready | output | 1 | Block can take a batch |
| in_last | input | 1 | Accompanying batch is the final one |
| in_words | input | NODES*WORD_W | One packed pattern word per node |
| out_valid | output | 1 | `out_cand` holds a candidate |
| out_ready | input | 1 | Consumer takes the candidate |
| out_cand | output | 2*IDXW+2 | Candidate {i, j, x, y} |
| scan_done | output | 1 | One-cycle pulse after the final candidate slot |

## Verification
The hardest state to reach from the ports is an interrupted emission in which stale records must not leak into the next run. The bench halts the consumer while a candidate is pending and pulses `start`. It then sends fresh batches and requires the new stream to match only those batches. Any leftover observed bit would suppress expected candidates and show up as a mismatch. The other hard case is a pair that stays constant across every pattern. Random words almost never produce one, so directed batches tie two nodes to fixed values, and derived nodes (AND, OR, inversion of random nodes) make real implications appear under random traffic and random back-pressure.

// File: rtl/imp_miner_pkg.sv
// Shared definitions for the implication candidate miner.
// Combination code within a pair record: bit index {value_of_i, value_of_j}.
package imp_miner_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_FOLD,
        ST_EMIT
    } mine_state_t;

    // Re-express a 4-bit record of pair (i,j) as the record of pair (j,i):
    // combinations 00 and 11 stay, 01 and 10 trade places.
    function automatic logic [3:0] swap_roles(input logic [3:0] c);
        return {c[3], c[1], c[2], c[0]};
    endfunction

endpackage

// File: rtl/imp_pair_fold.sv
// Reduces two packed pattern words to the four "combination present" bits.
// Assumes both words describe the same set of patterns bit for bit.
module imp_pair_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    output logic [3:0]   combo
);
    // Each bit tells whether any pattern shows the combination {a,b}.
    always_comb begin
        combo[0] = |(~a_word & ~b_word);
        combo[1] = |(~a_word &  b_word);
        combo[2] = |( a_word & ~b_word);
        combo[3] = |( a_word &  b_word);
    end
endmodule

// File: rtl/imp_seen_store.sv
// Register store of per-ordered-pair combination records.
// One update names an unordered pair (upd_i < upd_j expected); the store ORs the
// bits into (i,j) and the role-swapped bits into (j,i). Diagonal cells read zero.
module imp_seen_store
    import imp_miner_pkg::*;
#(
    parameter int NODES = 8,
    parameter int IDXW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            upd_en,
    input  logic [IDXW-1:0] upd_i,
    input  logic [IDXW-1:0] upd_j,
    input  logic [3:0]      upd_combo,
    input  logic [IDXW-1:0] rd_i,
    input  logic [IDXW-1:0] rd_j,
    output logic [3:0]      rd_combo
);
    localparam int CELLS = NODES * NODES;

    logic [CELLS*4-1:0] cells;

    for (genvar gi = 0; gi < NODES; gi++) begin : g_row
        for (genvar gj = 0; gj < NODES; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign cells[(gi*NODES+gj)*4 +: 4] = 4'b0000;
            end else begin : g_cell
                logic [3:0] rec_q;
                logic       hit_fwd;
                logic       hit_rev;
                assign hit_fwd = upd_en && (upd_i == IDXW'(gi)) && (upd_j == IDXW'(gj));
                assign hit_rev = upd_en && (upd_i == IDXW'(gj)) && (upd_j == IDXW'(gi));
                // Accumulate observed combinations; clear on reset or start.
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        rec_q <= 4'b0000;
                    end else if (hit_fwd) begin
                        rec_q <= rec_q | upd_combo;
                    end else if (hit_rev) begin
                        rec_q <= rec_q | swap_roles(upd_combo);
                    end
                end
                assign cells[(gi*NODES+gj)*4 +: 4] = rec_q;
            end
        end
    end

    // Read port used by the emission scan.
    always_comb begin
        rd_combo = cells[(int'(rd_i) * NODES + int'(rd_j)) * 4 +: 4];
    end
endmodule

// File: rtl/imp_cand_pick.sv
// Decides whether a pair record yields a candidate for antecedent value ante.
// A candidate needs the antecedent observed with exactly one consequent value,
// and the pair must show at least two combinations (not both constant).
module imp_cand_pick (
    input  logic [3:0] seen,
    input  logic       ante,
    output logic       hit,
    output logic       cons
);
    logic with_zero;
    logic with_one;
    logic two_or_more;

    // Evaluate the candidate rule for one antecedent value.
    always_comb begin
        with_zero   = seen[{ante, 1'b0}];
        with_one    = seen[{ante, 1'b1}];
        two_or_more = (seen & (seen - 4'd1)) != 4'd0;
        cons        = with_one;
        hit         = (with_zero ^ with_one) && two_or_more;
    end
endmodule

// File: rtl/implication_miner.sv
// Top of the implication candidate miner.
// Collects packed pattern batches, folds each one unordered pair per cycle into
// the combination store, then streams candidates in (i, j, x) order.
// Assumes NODES >= 2 and that the consumer honours valid/ready.
module implication_miner
    import imp_miner_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int WORD_W = 32,
    parameter int IDXW   = (NODES > 2) ? $clog2(NODES) : 1,
    parameter int CAND_W = 2 * IDXW + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_last,
    input  logic [NODES*WORD_W-1:0] in_words,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CAND_W-1:0]       out_cand,
    output logic                    scan_done
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NODES - 1);
    localparam logic [IDXW-1:0] ONE_IDX  = IDXW'(1);

    mine_state_t             state_q;
    logic [NODES*WORD_W-1:0] batch_q;
    logic                    last_q;
    logic [IDXW-1:0]         fi_q, fj_q;
    logic [IDXW-1:0]         ei_q, ej_q;
    logic                    ex_q;
    logic                    done_q;

    logic [WORD_W-1:0]       fold_a, fold_b;
    logic [3:0]              fold_combo;
    logic [3:0]              rd_combo;
    logic                    pick_hit, pick_cons;
    logic                    fold_end, row_end, emit_end, emit_step;
    logic [IDXW-1:0]         ej_next;

    // Select the two words of the pair under fold.
    always_comb begin
        fold_a = batch_q[int'(fi_q) * WORD_W +: WORD_W];
        fold_b = batch_q[int'(fj_q) * WORD_W +: WORD_W];
    end

    imp_pair_fold #(.W(WORD_W)) fold_i (
        .a_word (fold_a),
        .b_word (fold_b),
        .combo  (fold_combo)
    );

    imp_seen_store #(.NODES(NODES), .IDXW(IDXW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .upd_en    (state_q == ST_FOLD),
        .upd_i     (fi_q),
        .upd_j     (fj_q),
        .upd_combo (fold_combo),
        .rd_i      (ei_q),
        .rd_j      (ej_q),
        .rd_combo  (rd_combo)
    );

    imp_cand_pick pick_i (
        .seen (rd_combo),
        .ante (ex_q),
        .hit  (pick_hit),
        .cons (pick_cons)
    );

    // Cursor bookkeeping for the fold and emission scans.
    always_comb begin
        fold_end  = (fi_q == LAST_IDX - ONE_IDX) && (fj_q == LAST_IDX);
        row_end   = (ej_q == LAST_IDX) ||
                    ((ej_q == LAST_IDX - ONE_IDX) && (ei_q == LAST_IDX));
        emit_end  = row_end && (ei_q == LAST_IDX) && ex_q;
        emit_step = !pick_hit || out_ready;
        ej_next   = ej_q + ONE_IDX;
        if (ej_next == ei_q) begin
            ej_next = ej_q + IDXW'(2);
        end
    end

    // Output stream and input handshake.
    always_comb begin
        in_ready  = (state_q == ST_COLLECT);
        out_valid = (state_q == ST_EMIT) && pick_hit;
        out_cand  = {ei_q, ej_q, ex_q, pick_cons};
        scan_done = done_q;
    end

    // Run sequencing: collect, fold, repeat until last, then emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            batch_q <= '0;
            last_q  <= 1'b0;
            fi_q    <= '0;
            fj_q    <= '0;
            ei_q    <= '0;
            ej_q    <= '0;
            ex_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q <= ST_COLLECT;
            end else begin
                unique case (state_q)
                    ST_COLLECT: begin
                        if (in_valid) begin
                            batch_q <= in_words;
                            last_q  <= in_last;
                            fi_q    <= '0;
                            fj_q    <= ONE_IDX;
                            state_q <= ST_FOLD;
                        end
                    end
                    ST_FOLD: begin
                        if (fold_end) begin
                            state_q <= last_q ? ST_EMIT : ST_COLLECT;
                            ei_q    <= '0;
                            ej_q    <= ONE_IDX;
                            ex_q    <= 1'b0;
                        end else if (fj_q == LAST_IDX) begin
                            fi_q <= fi_q + ONE_IDX;
                            fj_q <= fi_q + IDXW'(2);
                        end else begin
                            fj_q <= fj_q + ONE_IDX;
                        end
                    end
                    ST_EMIT: begin
                        if (emit_step) begin
                            if (emit_end) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else if (!ex_q) begin
                                ex_q <= 1'b1;
                            end else if (row_end) begin
                                ex_q <= 1'b0;
                                ei_q <= ei_q + ONE_IDX;
                                ej_q <= '0;
                            end else begin
                                ex_q <= 1'b0;
                                ej_q <= ej_next;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/imp_miner_chk.sv
// Port-level protocol checks for implication_miner, attached by bind.
module imp_miner_chk #(
    parameter int IDXW   = 3,
    parameter int CAND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CAND_W-1:0] out_cand,
    input logic              scan_done
);
    // R2
    start_opens_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !out_valid));

    // R9
    held_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_cand)));

    // R6
    no_self_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cand[CAND_W-1 -: IDXW] != out_cand[2 +: IDXW]));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!out_valid && !in_ready));

    // R10
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !start) |=> (!in_ready && !out_valid && !scan_done));

    // R3
    fold_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !start) |=> !in_ready);

    // R11
    phases_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
endmodule

bind implication_miner imp_miner_chk #(.IDXW(IDXW), .CAND_W(CAND_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_cand  (out_cand),
    .scan_done (scan_done)
);

// File: tb/implication_miner_tb_top.sv
`timescale 1ns/100ps
module implication_miner_tb_top;
    localparam int N  = 8;
    localparam int W  = 32;
    localparam int IW = 3;
    localparam int CW = 2 * IW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_last = 1'b0;
    logic [N*W-1:0] in_words = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [CW-1:0] out_cand;
    logic          scan_done;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] bw [N];
    logic [3:0]   es [N][N];
    logic [CW-1:0] exp_c [128];
    int            exp_n;

    always #2.5 clk = ~clk;

    implication_miner #(.NODES(N), .WORD_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_last   (in_last),
        .in_words  (in_words),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_cand  (out_cand),
        .scan_done (scan_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Build one batch; mode picks the node relations.
    task automatic make_batch(input int mode);
        logic [W-1:0] r [4];
        for (int k = 0; k < 4; k++) begin
            r[k] = (mode == 2) ? ($urandom & $urandom) : $urandom;
        end
        bw[0] = r[0]; bw[1] = r[1]; bw[2] = r[2]; bw[3] = r[3];
        bw[4] = r[0] & r[1];
        bw[5] = r[2] | r[3];
        bw[6] = ~r[0];
        bw[7] = bw[4] & r[3];
        if (mode == 1) begin
            bw[0] = '0;
            bw[1] = '1;
        end
        if (mode == 3) begin
            for (int k = 4; k < N; k++) bw[k] = $urandom;
        end
    endtask

    // Reference record update, one pattern at a time (R4).
    task automatic absorb_batch();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i != j)
                    for (int p = 0; p < W; p++)
                        es[i][j][{bw[i][p], bw[j][p]}] = 1'b1;
    endtask

    // Expected stream from the candidate rule (R5, R6, R7, R8).
    task automatic build_expected();
        exp_n = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i != j)
                    for (int x = 0; x < 2; x++) begin
                        logic s0, s1;
                        s0 = es[i][j][2*x];
                        s1 = es[i][j][2*x+1];
                        if ($countones(es[i][j]) >= 2 && (s0 != s1)) begin
                            exp_c[exp_n] = {IW'(i), IW'(j), 1'(x), s1};
                            exp_n++;
                        end
                    end
    endtask

    task automatic begin_run();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) es[i][j] = 4'b0000;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(in_ready && !out_valid, "R2 start opens input",
              {30'd0, in_ready, out_valid}, 32'h2);
    endtask

    task automatic feed(input int nb, input int mode, input bit use_mode_mix);
        for (int b = 0; b < nb; b++) begin
            int guard = 0;
            make_batch(use_mode_mix ? int'($urandom % 4) : mode);
            absorb_batch();
            while (!in_ready && guard < 200) begin @(negedge clk); guard++; end
            check(in_ready, "R11 input ready for next batch", {31'd0, in_ready}, 32'd1);
            for (int k = 0; k < N; k++) in_words[k*W +: W] = bw[k];
            in_valid = 1'b1;
            in_last  = (b == nb - 1);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            check(!in_ready && !out_valid, "R3 folding blocks input",
                  {30'd0, in_ready, out_valid}, 32'd0);
        end
    endtask

    task automatic collect(input bit watch_const);
        int got = 0;
        int cyc = 0;
        bit fin = 0;
        int const_hits = 0;
        build_expected();
        while (!fin && cyc < 5000) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #1;
            cyc++;
            if (scan_done) begin
                fin = 1;
            end else if (out_valid && out_ready) begin
                if (watch_const &&
                    ((out_cand[CW-1 -: IW] < 2) && (out_cand[2 +: IW] < 2))) const_hits++;
                if (got < exp_n)
                    check(out_cand == exp_c[got], "R7 R8 candidate order and value",
                          32'(out_cand), 32'(exp_c[got]));
                else
                    check(1'b0, "R5 extra candidate", 32'(out_cand), 32'hffff);
                got++;
            end
        end
        out_ready = 1'b0;
        check(fin, "R10 scan_done pulse", {31'd0, fin}, 32'd1);
        check(got == exp_n, "R5 candidate count", got, exp_n);
        if (watch_const) check(const_hits == 0, "R6 constant pair silent", const_hits, 0);
        @(negedge clk);
        check(!in_ready && !out_valid && !scan_done, "R10 idle after scan",
              {29'd0, in_ready, out_valid, scan_done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1
        check(!in_ready && !out_valid && !scan_done, "R1 reset state",
              {29'd0, in_ready, out_valid, scan_done}, 32'd0);

        // Constant pair (nodes 0 and 1) with derived relations: R6, R4
        begin_run(); feed(1, 1, 0); collect(1);
        // Several batches accumulate before emission: R4, R11
        begin_run(); feed(3, 0, 0); collect(0);
        // Sparse words give many implications: R5
        begin_run(); feed(2, 2, 0); collect(0);
        // Dense random words leave few candidates
        begin_run(); feed(4, 3, 0); collect(0);

        // Abort mid-emission, then a fresh run must not see stale records: R2
        begin_run(); feed(1, 0, 0);
        begin
            int g = 0;
            out_ready = 1'b0;
            while (!out_valid && g < 500) begin @(negedge clk); g++; end
            check(out_valid, "R9 candidate pending before abort", {31'd0, out_valid}, 32'd1);
        end
        begin_run(); feed(2, 2, 0); collect(0);

        // Random runs with mixed modes and back-pressure
        for (int r = 0; r < 5; r++) begin
            begin_run(); feed(1 + int'($urandom % 3), 0, 1); collect(0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule